// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block controls 107 general-purpose pins. The pins are grouped into five banks of unequal width: 16, 27, 25, 27 and 12 pins. Each bank has its own set of registers. Software uses them to set output levels, enable the output drivers and read back the synchronised input levels. It also uses them to set up one interrupt per pin. Each pin interrupt can be edge- or level-triggered, can have either polarity, and can be masked. Its pending bit is cleared by writing a 1 to it.

The block sits behind a simple synchronous register port: a 6-bit address, a write strobe, 32-bit write data and combinational read data. The pad ring receives flat output and output-enable vectors and returns a flat input vector. A single level-sensitive interrupt request goes to the system interrupt controller. Pad electrical control, pin multiplexing and the bus bridge live outside this block.

Top module: `gpio_ctrl`

## Requirements
- R1: Address bits [5:3] select the bank and bits [2:0] select the register. Banks 0..4 cover pins 0..15, 16..42, 43..67, 68..94 and 95..106. In every register of a bank, the lowest pin of that bank sits at bit 0. The register codes are: 0 output value, 1 output enable, 2 input level, 3 trigger type (1 = edge, 0 = level), 4 polarity, 5 interrupt mask (1 = enabled), 6 clear, 7 pending status.
- R2: The output-value and output-enable registers drive `pin_o` and `pin_oe_o` from the clock edge that takes the write, and read back as written.
- R3: The input-level register returns the pin level two clock edges after the pin changes. This holds whether or not the pin's output enable is set.
- R4: When a pin is in edge mode, polarity 1 latches its pending bit on a rising edge and polarity 0 latches it on a falling edge. The bit is visible three clock edges after the pin changes.
- R5: When a pin is in level mode, its pending bit is set on every cycle in which the active level is present (polarity 1 = high, 0 = low). A clear has no effect while that level persists. The bit stays latched after the level goes away, until it is cleared.
- R6: Writing 1 to a bit of the clear register clears that pending bit. Writing 0 changes nothing. The clear register reads as 0.
- R7: If a new trigger event and a clear for the same bit fall in the same cycle, the bit stays pending.
- R8: `irq_o` is high exactly when some pending bit has its mask bit set. Pending bits latch even while masked.
- R9: Several accesses are ignored and read as 0: bits above a bank's width, banks 5..7, and writes to the input-level and status registers.
- R10: After reset, output value, output enable, mask and pending status are 0, and trigger type and polarity are all ones (rising edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register address: bank in [5:3], register in [2:0] |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_i | input | 107 | Pin levels from the pads |
| pin_o | output | 107 | Output value for each pin |
| pin_oe_o | output | 107 | Output driver enable for each pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed latency, counted in clock edges:
- Register writes appear on `pin_o`, `pin_oe_o` and read data one edge after the write strobe is sampled.
- The input level reads back after two edges.
- A pending bit, and `irq_o` with it, follows a pin change after three edges.

The bench drives every input at the falling edge. For each stimulus it waits the full latency, or longer, before sampling at a later falling edge. Two directed tests pin the exact cycle. One reads the input register after one edge and again after two, to check the synchroniser depth. The other places a clear write on exactly the third edge after a pin rises, so that the clear and the new edge collide.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NB = 5;
  localparam int BW [NB] = '{16, 27, 25, 27, 12};

  function automatic int bank_base(input int b);
    int s;
    s = 0;
    for (int i = 0; i < NB; i++) if (i < b) s += BW[i];
    return s;
  endfunction

  localparam int NPIN    = bank_base(NB);
  localparam int BANK_AW = $clog2(NB);
  localparam int REG_AW  = 3;
  localparam int ADDR_W  = BANK_AW + REG_AW;

  typedef enum logic [REG_AW-1:0] {
    REG_OUT  = 3'd0,
    REG_OE   = 3'd1,
    REG_IN   = 3'd2,
    REG_TRIG = 3'd3,
    REG_POL  = 3'd4,
    REG_IEN  = 3'd5,
    REG_CLR  = 3'd6,
    REG_STAT = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q, lvl_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prv_q  <= lvl_q;
    end
  end

  assign lvl_o = lvl_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prv_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] set_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = lvl_i[i] & ~prv_i[i];
    assign fall     = ~lvl_i[i] & prv_i[i];
    assign edge_hit = pol_i[i] ? rise : fall;
    assign lvl_hit  = pol_i[i] ? lvl_i[i] : ~lvl_i[i];
    assign hit[i]   = trig_i[i] ? edge_hit : lvl_hit;
  end

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | hit;
  end

  assign set_o  = hit;
  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  pin_i,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic [W-1:0]  stat_o,
  output logic [W-1:0]  set_o,
  output logic [W-1:0]  clr_o,
  output logic [W-1:0]  ien_o
);
  logic [W-1:0] out_q, oe_q, trig_q, pol_q, ien_q;
  logic [W-1:0] lvl, prv, pend, clr;
  logic [W-1:0] wd;

  assign wd = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oe_q   <= '0;
      trig_q <= '1;
      pol_q  <= '1;
      ien_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        REG_OUT:  out_q  <= wd;
        REG_OE:   oe_q   <= wd;
        REG_TRIG: trig_q <= wd;
        REG_POL:  pol_q  <= wd;
        REG_IEN:  ien_q  <= wd;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_i && sel_i == REG_CLR) ? wd : '0;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .prv_i (prv),
    .trig_i(trig_q),
    .pol_i (pol_q),
    .clr_i (clr),
    .set_o (set_o),
    .pend_o(pend)
  );

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      REG_OUT:  rdata_o[W-1:0] = out_q;
      REG_OE:   rdata_o[W-1:0] = oe_q;
      REG_IN:   rdata_o[W-1:0] = lvl;
      REG_TRIG: rdata_o[W-1:0] = trig_q;
      REG_POL:  rdata_o[W-1:0] = pol_q;
      REG_IEN:  rdata_o[W-1:0] = ien_q;
      REG_STAT: rdata_o[W-1:0] = pend;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = oe_q;
  assign irq_o    = |(pend & ien_q);
  assign stat_o   = pend;
  assign clr_o    = clr;
  assign ien_o    = ien_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [BANK_AW-1:0] bank_idx;
  reg_sel_e           reg_sel;
  logic [DW-1:0]      bank_rd  [NB];
  logic [NB-1:0]      bank_irq;
  logic [NPIN-1:0]    stat_all, set_all, clr_all, ien_all;

  assign bank_idx = addr_i[ADDR_W-1:REG_AW];
  assign reg_sel  = reg_sel_e'(addr_i[REG_AW-1:0]);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    localparam int W = BW[g];
    localparam int B = bank_base(g);
    logic wr;
    assign wr = we_i && (int'(bank_idx) == g);

    gpio_bank #(.W(W), .DW(DW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .sel_i   (reg_sel),
      .wdata_i (wdata_i),
      .pin_i   (pin_i[B +: W]),
      .pin_o   (pin_o[B +: W]),
      .pin_oe_o(pin_oe_o[B +: W]),
      .rdata_o (bank_rd[g]),
      .irq_o   (bank_irq[g]),
      .stat_o  (stat_all[B +: W]),
      .set_o   (set_all[B +: W]),
      .clr_o   (clr_all[B +: W]),
      .ien_o   (ien_all[B +: W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++)
      if (int'(bank_idx) == i) rdata_o = bank_rd[i];
  end

  assign irq_o = |bank_irq;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic [NPIN-1:0]   pin_o,
  input logic [NPIN-1:0]   pin_oe_o,
  input logic [NPIN-1:0]   stat_all,
  input logic [NPIN-1:0]   set_all,
  input logic [NPIN-1:0]   clr_all,
  input logic [NPIN-1:0]   ien_all
);
  logic bad_bank_wr;
  assign bad_bank_wr = we_i && (int'(addr_i[ADDR_W-1:REG_AW]) >= NB);

  assert_irq_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_all & ien_all)) |-> irq_o);

  assert_irq_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_all & ien_all)) |-> !irq_o);

  assert_drop_needs_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_all) & ~stat_all) & ~$past(clr_all)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_all & $past(set_all)) == $past(set_all)));

  assert_bad_bank_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_bank_wr |=> ($stable(pin_o) && $stable(pin_oe_o) && $stable(ien_all)));
endmodule

bind gpio_ctrl gpio_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .irq_o   (irq_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .stat_all(stat_all),
  .set_all (set_all),
  .clr_all (clr_all),
  .ien_all (ien_all)
);

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int PERIOD = 10;
  localparam int NP = 107;

  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_P = 3'd2,
                         OP_O = 3'd3, OP_E = 3'd4, OP_Q = 3'd5;
  localparam logic [2:0] RO = 3'd0, ROE = 3'd1, RIN = 3'd2, RTRG = 3'd3,
                         RPOL = 3'd4, RIEN = 3'd5, RCLR = 3'd6, RST = 3'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  bank;
    logic [2:0]  rs;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t TAB [NV] = '{
    // R10 reset values
    '{OP_R, 3'd1, RTRG, 32'h0, 32'h7FFFFFF, 4'd10},
    '{OP_R, 3'd1, RPOL, 32'h0, 32'h7FFFFFF, 4'd10},
    '{OP_R, 3'd1, RIEN, 32'h0, 32'h0, 4'd10},
    '{OP_R, 3'd0, RST,  32'h0, 32'h0, 4'd10},
    '{OP_Q, 3'd0, RO,   32'h0, 32'h0, 4'd10},
    // R2 output value and enable
    '{OP_W, 3'd0, RO,   32'hA5A5, 32'h0, 4'd2},
    '{OP_O, 3'd0, RO,   32'h0, 32'hA5A5, 4'd2},
    '{OP_R, 3'd0, RO,   32'h0, 32'hA5A5, 4'd2},
    '{OP_W, 3'd0, ROE,  32'h00FF, 32'h0, 4'd2},
    '{OP_E, 3'd0, RO,   32'h0, 32'h00FF, 4'd2},
    '{OP_R, 3'd0, ROE,  32'h0, 32'h00FF, 4'd2},
    // R9 bits above width, R1 top bank on pins 95..106
    '{OP_W, 3'd4, RO,   32'hFFFFFFFF, 32'h0, 4'd9},
    '{OP_R, 3'd4, RO,   32'h0, 32'hFFF, 4'd9},
    '{OP_O, 3'd4, RO,   32'h0, 32'hFFF, 4'd1},
    '{OP_O, 3'd3, RO,   32'h0, 32'h0, 4'd1},
    // R9 nonexistent bank
    '{OP_W, 3'd5, RO,   32'h1234, 32'h0, 4'd9},
    '{OP_R, 3'd5, RO,   32'h0, 32'h0, 4'd9},
    '{OP_O, 3'd0, RO,   32'h0, 32'hA5A5, 4'd9},
    '{OP_O, 3'd4, RO,   32'h0, 32'hFFF, 4'd9},
    // R3/R4 rising edge on pin 43, R8 masked latch
    '{OP_P, 3'd2, RO,   32'h1, 32'h0, 4'd3},
    '{OP_R, 3'd2, RIN,  32'h0, 32'h1, 4'd3},
    '{OP_R, 3'd2, RST,  32'h0, 32'h1, 4'd4},
    '{OP_Q, 3'd0, RO,   32'h0, 32'h0, 4'd8},
    '{OP_W, 3'd2, RIEN, 32'h1, 32'h0, 4'd8},
    '{OP_Q, 3'd0, RO,   32'h0, 32'h1, 4'd8},
    // R6 clear semantics
    '{OP_W, 3'd2, RCLR, 32'h0, 32'h0, 4'd6},
    '{OP_R, 3'd2, RST,  32'h0, 32'h1, 4'd6},
    '{OP_R, 3'd2, RCLR, 32'h0, 32'h0, 4'd6},
    '{OP_W, 3'd2, RCLR, 32'h1, 32'h0, 4'd6},
    '{OP_R, 3'd2, RST,  32'h0, 32'h0, 4'd6},
    '{OP_Q, 3'd0, RO,   32'h0, 32'h0, 4'd6},
    // R4 falling edge
    '{OP_W, 3'd2, RPOL, 32'h1FFFFFE, 32'h0, 4'd4},
    '{OP_P, 3'd2, RO,   32'h0, 32'h0, 4'd4},
    '{OP_R, 3'd2, RST,  32'h0, 32'h1, 4'd4},
    '{OP_W, 3'd2, RCLR, 32'h1, 32'h0, 4'd4},
    '{OP_R, 3'd2, RST,  32'h0, 32'h0, 4'd4},
    // R9 read-only registers
    '{OP_W, 3'd2, RST,  32'hFFFF, 32'h0, 4'd9},
    '{OP_R, 3'd2, RST,  32'h0, 32'h0, 4'd9},
    '{OP_W, 3'd2, RIN,  32'hFFFF, 32'h0, 4'd9},
    '{OP_R, 3'd2, RIN,  32'h0, 32'h0, 4'd9},
    // R5 active-high level on bank 3
    '{OP_W, 3'd3, RTRG, 32'h0, 32'h0, 4'd5},
    '{OP_P, 3'd3, RO,   32'h0, 32'h0, 4'd5},
    '{OP_R, 3'd3, RST,  32'h0, 32'h0, 4'd5},
    '{OP_P, 3'd3, RO,   32'h4, 32'h0, 4'd5},
    '{OP_R, 3'd3, RST,  32'h0, 32'h4, 4'd5},
    '{OP_W, 3'd3, RCLR, 32'h4, 32'h0, 4'd5},
    '{OP_R, 3'd3, RST,  32'h0, 32'h4, 4'd5},
    '{OP_P, 3'd3, RO,   32'h0, 32'h0, 4'd5},
    '{OP_R, 3'd3, RST,  32'h0, 32'h4, 4'd5},
    '{OP_W, 3'd3, RCLR, 32'h4, 32'h0, 4'd5},
    '{OP_R, 3'd3, RST,  32'h0, 32'h0, 4'd5},
    // R5 active-low level on bank 4 bit 0
    '{OP_W, 3'd4, RTRG, 32'h0, 32'h0, 4'd5},
    '{OP_W, 3'd4, RPOL, 32'hFFE, 32'h0, 4'd5},
    '{OP_P, 3'd4, RO,   32'h0, 32'h0, 4'd5},
    '{OP_R, 3'd4, RST,  32'h0, 32'h1, 4'd5},
    // R1 bank 1 top bit is pin 42, pin 43 unaffected
    '{OP_P, 3'd1, RO,   32'h4000000, 32'h0, 4'd1},
    '{OP_R, 3'd1, RIN,  32'h0, 32'h4000000, 4'd1},
    '{OP_R, 3'd1, RST,  32'h0, 32'h4000000, 4'd1},
    '{OP_R, 3'd2, RIN,  32'h0, 32'h0, 4'd1},
    // R3 input readback while output enabled
    '{OP_P, 3'd0, RO,   32'h0081, 32'h0, 4'd3},
    '{OP_R, 3'd0, RIN,  32'h0, 32'h0081, 4'd3}
  };

  logic          clk, rst_n, we, irq;
  logic [5:0]    addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pins, pout, poe;
  int total, bad;

  gpio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic int tb_base(input int b);
    case (b)
      0: return 0;
      1: return 16;
      2: return 43;
      3: return 68;
      default: return 95;
    endcase
  endfunction

  function automatic int tb_w(input int b);
    case (b)
      0: return 16;
      1: return 27;
      2: return 25;
      3: return 27;
      default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] slice(input logic [NP-1:0] v, input int b);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < tb_w(b); k++) r[k] = v[tb_base(b) + k];
    return r;
  endfunction

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] b, input logic [2:0] r, input logic [31:0] d);
    addr = {b, r}; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic drive_pins(input int b, input logic [31:0] d);
    for (int k = 0; k < tb_w(b); k++) pins[tb_base(b) + k] = d[k];
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(10, {31'd0, irq}, 32'h0, "irq in reset");
    chk(10, {31'd0, |pout}, 32'h0, "pin_o in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TAB[i];
      case (v.op)
        OP_W: bus_wr(v.bank, v.rs, v.data);
        OP_R: begin
          addr = {v.bank, v.rs}; #1;
          chk(int'(v.req), rdata, v.exp, $sformatf("row %0d read", i));
        end
        OP_P: drive_pins(int'(v.bank), v.data);
        OP_O: chk(int'(v.req), slice(pout, int'(v.bank)), v.exp, $sformatf("row %0d pin_o", i));
        OP_E: chk(int'(v.req), slice(poe, int'(v.bank)), v.exp, $sformatf("row %0d pin_oe", i));
        OP_Q: chk(int'(v.req), {31'd0, irq}, v.exp, $sformatf("row %0d irq", i));
        default: ;
      endcase
    end

    // R3 synchroniser depth: pin 16 visible after the second edge, not the first
    addr = {3'd1, RIN};
    pins[16] = 1'b1;
    @(negedge clk); #1;
    chk(3, rdata, 32'h4000000, "input after one edge");
    @(negedge clk); #1;
    chk(3, rdata, 32'h4000001, "input after two edges");

    // R7 clear and new rising edge on pin 3 in the same cycle
    drive_pins(0, 32'h0089);
    drive_pins(0, 32'h0081);
    addr = {3'd0, RST}; #1;
    chk(4, rdata, 32'h0089, "pending before collision");
    pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr(3'd0, RCLR, 32'h0008);
    addr = {3'd0, RST}; #1;
    chk(7, rdata, 32'h0089, "edge beats clear");
    bus_wr(3'd0, RCLR, 32'h0008);
    addr = {3'd0, RST}; #1;
    chk(6, rdata, 32'h0081, "clear after collision");

    // R10 reset mid-run
    pins = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(10, slice(pout, 0), 32'h0, "pin_o after reset");
    chk(10, slice(poe, 0), 32'h0, "pin_oe after reset");
    chk(10, {31'd0, irq}, 32'h0, "irq after reset");
    @(negedge clk);
    rst_n = 1'b1;
    addr = {3'd0, RST}; #1;
    chk(10, rdata, 32'h0, "status after reset");
    addr = {3'd2, RPOL}; #1;
    chk(10, rdata, 32'h1FFFFFF, "polarity after reset");

    summary();
  end
endmodule